// File: doc/BRIEF.md
# Supply-Fail Reset Generator

This block produces the system reset for a chip from a single comparator flag that reports when the supply is below its trip point. The flag is asynchronous to the clock, so it first passes through a two-flop synchronizer. A dip-length filter then removes short supply dips. Only a low-supply condition that lasts past the filter window asserts reset.

Once the condition clears, reset stays active for a long hold time before it releases. The filter window and the hold time are given in milliseconds and turned into clock cycles from the clock-frequency parameter. A simulation build therefore sets a small frequency to get short windows. One parameter selects whether the reset output is active high or active low.

At power-on the block holds reset active. The hold timer counts only cycles in which the synchronized flag reads inactive. A qualified dip during the hold clears the count, so the full hold time starts again.

Top module: `supply_reset_gen`

With `F = CLK_HZ*FILT_MS/1000` and `H = CLK_HZ*HOLD_MS/1000` (each at least 1):

## Requirements
- R1: While `por_n_i` is low, and after it rises until the hold time has run out, reset is active at `rst_o`.
- R2: Start from a state where reset is active because of power-on or a qualified dip. Drive `supply_low_i` low and keep it low. Reset then goes inactive on exactly the (H+2)-th rising clock edge after that change.
- R3: While reset is inactive, a high pulse on `supply_low_i` that spans F clock cycles or fewer leaves `rst_o` inactive throughout.
- R4: While reset is inactive, a high level on `supply_low_i` that lasts at least F+1 cycles makes reset active on the (F+3)-th rising edge after the level rises.
- R5: A qualified dip (F+1 or more cycles) that arrives during the hold restarts the full hold. Reset then releases on the (H+2)-th edge after that dip ends.
- R6: A dip of L ≤ F cycles during the hold pauses the hold count and does not clear it. Reset then releases L cycles later than it would without the dip.
- R7: With `ACTIVE_HIGH=1`, active reset is a 1 on `rst_o`. With `ACTIVE_HIGH=0`, active reset is a 0. In both builds the output is the exact complement of the other build's output for the same stimulus.
- R8: `rst_o` is always driven to a known 0 or 1 and is never X or Z.
- R9: F and H are computed from `CLK_HZ`, `FILT_MS` and `HOLD_MS`. For example, CLK_HZ=10000 with 4 ms and 140 ms gives F=40 and H=1400.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| supply_low_i | input | 1 | Asynchronous comparator flag, 1 = supply below threshold |
| rst_o | output | 1 | System reset, polarity set by `ACTIVE_HIGH` |

## Verification
The only output is a single reset level, so a fault inside the block shows up as a release or an assertion on the wrong clock edge. Typical faults are a filter counter that saturates early, a hold counter that restarts on a short dip, or a synchronizer missing a stage. The release edge shows the hold count to within one cycle, at most H+2 edges after the flag clears. The assertion edge shows the filter length within F+3 edges of a dip. The block is compared edge by edge against a cycle model, and both polarity builds run on the same stimulus. A polarity or stage-count error is therefore visible on the first cycle it matters.

// File: rtl/supply_reset_pkg.sv
package supply_reset_pkg;

  // Convert a duration in milliseconds to a clock-cycle count, at least 1.
  function automatic int unsigned cycles_for_ms(longint unsigned hz, int unsigned ms);
    longint unsigned c;
    c = (hz * longint'(ms)) / 1000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  typedef enum logic {
    OUT_ACTIVE_LOW  = 1'b0,
    OUT_ACTIVE_HIGH = 1'b1
  } out_pol_e;

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        INIT   = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= INIT;
          else         chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= INIT;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/dip_filter.sv
module dip_filter #(
  parameter int unsigned FILT_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_i,
  output logic fault_o
);
  localparam int unsigned RW = $clog2(FILT_CYC + 1) < 1 ? 1 : $clog2(FILT_CYC + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(FILT_CYC);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            run_q <= '0;
    else if (!low_i)        run_q <= '0;
    else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
  end

  assign fault_o = low_i && (run_q == RUN_MAX);

  // R4: a qualified dip needs the flag high on the previous cycle as well
  p_fault_needs_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(low_i));
  // R3: the flag dropping clears the qualification on the next cycle
  p_drop_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !low_i |=> !fault_o);
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int unsigned HOLD_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  input  logic low_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1) < 1 ? 1 : $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (fault_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q && !low_i) begin
      if (cnt_q == LAST) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = act_q;

  // R5: a qualified dip leaves reset active with a cleared count
  p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> (act_q && cnt_q == '0));
  // R2: release only after the full count
  p_full_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q) |-> ($past(cnt_q) == LAST));
  // R6: a short dip holds the count still
  p_pause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && low_i && !fault_i) |=> $stable(cnt_q));
endmodule

// File: rtl/supply_reset_gen.sv
module supply_reset_gen
  import supply_reset_pkg::*;
#(
  parameter longint unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned     FILT_MS     = 4,
  parameter int unsigned     HOLD_MS     = 140,
  parameter int unsigned     SYNC_STAGES = 2,
  parameter bit              ACTIVE_HIGH = 1'b0
) (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic supply_low_i,
  output logic rst_o
);
  localparam int unsigned FILT_CYC = cycles_for_ms(CLK_HZ, FILT_MS);
  localparam int unsigned HOLD_CYC = cycles_for_ms(CLK_HZ, HOLD_MS);
  localparam out_pol_e    POL      = ACTIVE_HIGH ? OUT_ACTIVE_HIGH : OUT_ACTIVE_LOW;

  logic low_s;
  logic fault;
  logic active;

  flag_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (por_n_i),
    .async_i(supply_low_i),
    .sync_o (low_s)
  );

  dip_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (por_n_i),
    .low_i  (low_s),
    .fault_o(fault)
  );

  hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (por_n_i),
    .fault_i (fault),
    .low_i   (low_s),
    .active_o(active)
  );

  generate
    if (POL == OUT_ACTIVE_HIGH) begin : g_hi
      assign rst_o = active;
    end else begin : g_lo
      assign rst_o = ~active;
    end
  endgenerate

  // R8: output always at a defined level
  p_known_r8: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !$isunknown(rst_o));
  // R4: a qualified dip shows as active reset at the pin on the next cycle
  p_fault_to_pin_r4: assert property (@(posedge clk_i) disable iff (!por_n_i)
    fault |=> (rst_o == ACTIVE_HIGH));
endmodule

// File: tb/tb_supply_reset_gen.sv
`timescale 1ns/1ps
module tb_supply_reset_gen;
  localparam longint unsigned HZ = 10000;
  localparam int F = 40;    // R9: 10000*4/1000
  localparam int H = 1400;  // R9: 10000*140/1000

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic sl = 1'b1;
  logic rst_n_o, rst_hi_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  supply_reset_gen #(.CLK_HZ(HZ), .ACTIVE_HIGH(1'b0)) dut (
    .clk_i(clk), .por_n_i(por_n), .supply_low_i(sl), .rst_o(rst_n_o));
  supply_reset_gen #(.CLK_HZ(HZ), .ACTIVE_HIGH(1'b1)) dut_hi (
    .clk_i(clk), .por_n_i(por_n), .supply_low_i(sl), .rst_o(rst_hi_o));

  // Cycle model built from R1..R6.
  logic m_s1, m_s2, m_act;
  int   m_run, m_cnt;
  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_run <= 0; m_act <= 1'b1; m_cnt <= 0;
    end else begin
      m_s1 <= sl;
      m_s2 <= m_s1;
      m_run <= m_s2 ? ((m_run == F) ? F : m_run + 1) : 0;
      if (m_s2 && m_run == F) begin
        m_act <= 1'b1; m_cnt <= 0;
      end else if (m_act && !m_s2) begin
        if (m_cnt == H - 1) begin m_act <= 1'b0; m_cnt <= 0; end
        else m_cnt <= m_cnt + 1;
      end
    end
  end

  function automatic logic exp_low_pin(logic act);
    return act ? 1'b0 : 1'b1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Edge-by-edge comparison against the model, both polarities (R7, R8).
  always @(negedge clk) begin
    if (!done) begin
      check("R7 active-low pin", {31'b0, rst_n_o}, {31'b0, exp_low_pin(m_act)});
      check("R7 active-high pin", {31'b0, rst_hi_o}, {31'b0, m_act});
      check("R8 known level", {31'b0, $isunknown(rst_n_o) | $isunknown(rst_hi_o)}, 32'd0);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Count negedges until the active-low pin reads 1, with a limit.
  task automatic edges_to_release(output int k);
    k = 0;
    while (rst_n_o !== 1'b1 && k < 4 * H) begin @(negedge clk); k++; end
  endtask

  task automatic edges_to_assert(output int k);
    k = 0;
    while (rst_n_o !== 1'b0 && k < 4 * F + 10) begin @(negedge clk); k++; end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    int k;
    int saw;
    void'($urandom(32'd7531));
    step(5);
    check("R1 reset during por", {31'b0, rst_n_o}, 32'd0);
    check("R1 reset during por hi", {31'b0, rst_hi_o}, 32'd1);
    // R1/R2: release from power-on with the flag clear
    sl = 1'b0; por_n = 1'b1;
    step(H / 2);
    check("R1 still held", {31'b0, rst_n_o}, 32'd0);
    edges_to_release(k);
    check("R2 release edge after por", k + H / 2, H + 2);
    step(10);
    // R3: dip of exactly F cycles ignored
    saw = 0;
    sl = 1'b1; repeat (F) begin @(negedge clk); if (rst_n_o === 1'b0) saw = 1; end
    sl = 1'b0; repeat (F + 10) begin @(negedge clk); if (rst_n_o === 1'b0) saw = 1; end
    check("R3 short dip ignored", saw, 0);
    // R4: dip of F+1 cycles asserts on edge F+3
    sl = 1'b1;
    edges_to_assert(k);
    check("R4 assert edge", k, F + 3);
    // R2: release H+2 edges after the flag clears
    sl = 1'b0;
    edges_to_release(k);
    check("R2 release edge after dip", k, H + 2);
    step(10);
    // R5: qualified dip during hold restarts
    sl = 1'b1; step(F + 5); sl = 1'b0;
    step(100);
    sl = 1'b1; step(F + 1); sl = 1'b0;
    edges_to_release(k);
    check("R5 restart release edge", k, H + 2);
    step(10);
    // R6: short dip during hold pauses the count
    sl = 1'b1; step(F + 5); sl = 1'b0;
    step(100);
    sl = 1'b1; step(5); sl = 1'b0;
    edges_to_release(k);
    check("R6 pause release edge", k + 105, H + 2 + 5);
    step(10);
    // Random dips around the filter boundary; the model checks every edge.
    for (int i = 0; i < 40; i++) begin
      sl = 1'b1; step(F - 8 + int'($urandom_range(0, 16)));
      sl = 1'b0; step(int'($urandom_range(0, 1800)));
    end
    step(H + 10);
    check("R2 final release", {31'b0, rst_n_o}, 32'd1);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule